// File: doc/BRIEF.md
# Program Counter Branch Unit

This unit decides where the program counter goes after a control-flow operation and how long the fetch stage must stall while it does so. Decode supplies an operation code together with the current program counter, a signed offset, a 16-bit pointer value, a return address popped from the stack, the status byte, a bit index, a skip condition and a flag that says whether the following instruction occupies two words. The unit latches the operation, raises `busy` for the number of execution cycles the operation needs, and presents the new program counter with a one-cycle `pcLoad` strobe in the last of those cycles.

Calls also ask the stack to save the return address. That request is issued in the first busy cycle, two cycles before the new program counter is committed, so the push has completed before the jump takes effect. A return from interrupt raises a strobe with the commit so that the global interrupt enable can be set again. All address arithmetic wraps modulo 2^PC_W.

Top module: `pc_branch_unit`

## Requirements
- R1: Op code 0 (relative jump) gives nextPc = curPc + sign-extended offset + 1, modulo 2^PC_W, and takes 2 cycles.
- R2: Op code 1 (indirect jump) gives nextPc = the low PC_W bits of ptrVal and takes 2 cycles.
- R3: Op codes 2 (relative call, target as R1) and 3 (indirect call, target as R2) take 3 cycles; pushReq is high only in the first busy cycle, with pushAddr = curPc + 1, two cycles before pcLoad.
- R4: Op codes 4 (return) and 5 (return from interrupt) give nextPc = retAddr and take 4 cycles; intEnableSet is high in the pcLoad cycle for code 5 and never for code 4.
- R5: Op codes 6 (branch if statusReg[bitSel] is 1) and 7 (branch if it is 0): when taken, nextPc = curPc + sign-extended offset + 1 in 2 cycles; when not taken, nextPc = curPc + 1 in 1 cycle.
- R6: Op codes 8 and 9 are signed branches on statusReg[2] XOR statusReg[3]: code 8 is taken when the XOR is 0, code 9 when it is 1; targets and cycles as R5.
- R7: Op code 10 (skip): with skipCond 0, nextPc = curPc + 1 in 1 cycle; with skipCond 1 and nextTwoWord 0, curPc + 2 in 2 cycles; with skipCond 1 and nextTwoWord 1, curPc + 3 in 3 cycles.
- R8: An op is accepted on a clock edge where opValid is 1 and busy is 0; busy is then high for exactly cycLen cycles starting the next cycle, pcLoad is high in the last of them only, and cycLen holds the operation's cycle count.
- R9: opValid and all operand inputs are ignored while busy is high: the running operation's timing, nextPc and strobes are unchanged.
- R10: After reset busy, pcLoad, pushReq and intEnableSet are 0, and nextPc, pushAddr and cycLen are 0.
- R11: Op codes 11 to 15 give nextPc = curPc + 1 in 1 cycle with no push and no interrupt-enable strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation present on the operand inputs |
| opKind | input | 4 | Operation code |
| curPc | input | PC_W | Program counter of the operation |
| offset | input | OFF_W | Signed relative offset |
| ptrVal | input | PTR_W | Pointer register for indirect targets |
| retAddr | input | PC_W | Return address popped from the stack |
| statusReg | input | SREG_W | Status byte |
| bitSel | input | SEL_W | Status bit index for codes 6 and 7 |
| skipCond | input | 1 | Skip condition is true |
| nextTwoWord | input | 1 | The following instruction is two words long |
| busy | output | 1 | Operation in progress, fetch stalled |
| cycLen | output | CNT_W | Cycle count of the latest operation |
| pcLoad | output | 1 | Commit strobe for nextPc |
| nextPc | output | PC_W | New program counter |
| pushReq | output | 1 | Push pushAddr on the stack |
| pushAddr | output | PC_W | Return address to save |
| intEnableSet | output | 1 | Set the global interrupt enable |

## Verification
The assertions assume that opValid is only sampled when busy is low and that the operands of an accepted op are those present on its accept edge; they place no constraint on inputs during busy, which is exactly what R9 relies on. The stimulus drives each operation for one accept edge, then either drops opValid or, in the intrusion cases, keeps it high with scrambled operands until the commit cycle, so the timing properties and the hold of nextPc are exercised both ways. Random operands cover all sixteen op codes, every status bit index and both skip sizes, while directed cases hit the wrap at the top of the address space and negative offsets.

// File: rtl/pcbu_pkg.sv
package pcbu_pkg;

  localparam logic [3:0] OP_RJMP  = 4'd0;
  localparam logic [3:0] OP_IJMP  = 4'd1;
  localparam logic [3:0] OP_RCALL = 4'd2;
  localparam logic [3:0] OP_ICALL = 4'd3;
  localparam logic [3:0] OP_RET   = 4'd4;
  localparam logic [3:0] OP_RETI  = 4'd5;
  localparam logic [3:0] OP_BRSET = 4'd6;
  localparam logic [3:0] OP_BRCLR = 4'd7;
  localparam logic [3:0] OP_BRGE  = 4'd8;
  localparam logic [3:0] OP_BRLT  = 4'd9;
  localparam logic [3:0] OP_SKIP  = 4'd10;

  // status bit positions used by the signed conditions
  localparam int NEG_BIT = 2;
  localparam int OVF_BIT = 3;

  typedef enum logic [2:0] {
    SEL_SEQ,
    SEL_REL,
    SEL_PTR,
    SEL_RET,
    SEL_SKIP2,
    SEL_SKIP3
  } pcSel_e;

  typedef struct packed {
    logic   latch;
    pcSel_e sel;
  } dpCtrl_t;

endpackage

// File: rtl/pcbu_ctrl.sv
module pcbu_ctrl
  import pcbu_pkg::*;
#(
  parameter int SREG_W = 8,
  parameter int SEL_W  = $clog2(SREG_W),
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opKind,
  input  logic [SREG_W-1:0] statusReg,
  input  logic [SEL_W-1:0]  bitSel,
  input  logic              skipCond,
  input  logic              nextTwoWord,
  output dpCtrl_t           dpCtrl,
  output logic              busy,
  output logic [CNT_W-1:0]  cycLen,
  output logic              pcLoad,
  output logic              pushReq,
  output logic              intEnableSet
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len;
  logic             callQ;
  logic             retiQ;
  logic             isCall;
  logic             isReti;
  logic             accept;
  logic             selBit;
  logic             signedLt;
  pcSel_e           sel;

  assign busy     = (cnt != '0);
  assign accept   = opValid && !busy;
  assign selBit   = statusReg[bitSel];
  assign signedLt = statusReg[NEG_BIT] ^ statusReg[OVF_BIT];

  always_comb begin
    sel    = SEL_SEQ;
    len    = CNT_W'(1);
    isCall = 1'b0;
    isReti = 1'b0;
    case (opKind)
      OP_RJMP:  begin sel = SEL_REL; len = CNT_W'(2); end
      OP_IJMP:  begin sel = SEL_PTR; len = CNT_W'(2); end
      OP_RCALL: begin sel = SEL_REL; len = CNT_W'(3); isCall = 1'b1; end
      OP_ICALL: begin sel = SEL_PTR; len = CNT_W'(3); isCall = 1'b1; end
      OP_RET:   begin sel = SEL_RET; len = CNT_W'(4); end
      OP_RETI:  begin sel = SEL_RET; len = CNT_W'(4); isReti = 1'b1; end
      OP_BRSET: if (selBit)    begin sel = SEL_REL; len = CNT_W'(2); end
      OP_BRCLR: if (!selBit)   begin sel = SEL_REL; len = CNT_W'(2); end
      OP_BRGE:  if (!signedLt) begin sel = SEL_REL; len = CNT_W'(2); end
      OP_BRLT:  if (signedLt)  begin sel = SEL_REL; len = CNT_W'(2); end
      OP_SKIP: begin
        if (skipCond) begin
          if (nextTwoWord) begin sel = SEL_SKIP3; len = CNT_W'(3); end
          else             begin sel = SEL_SKIP2; len = CNT_W'(2); end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      cycLen <= '0;
      callQ  <= 1'b0;
      retiQ  <= 1'b0;
    end else if (accept) begin
      cnt    <= len;
      cycLen <= len;
      callQ  <= isCall;
      retiQ  <= isReti;
    end else if (busy) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign pcLoad       = (cnt == CNT_W'(1));
  assign pushReq      = callQ && busy && (cnt == cycLen);
  assign intEnableSet = retiQ && pcLoad;

  assign dpCtrl.latch = accept;
  assign dpCtrl.sel   = sel;

  // R8: an accepted op makes the unit busy in the next cycle
  a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !busy) |=> busy);
  // R8: busy stays up until the commit cycle
  a_r8_busy_until_load: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !pcLoad) |=> busy);
  // R8: commit is the last busy cycle
  a_r8_load_ends: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |=> !busy);
  // R3: the push is issued two cycles ahead of the commit
  a_r3_push_before_load: assert property (@(posedge clk) disable iff (!rstN)
    pushReq |-> ##2 pcLoad);
  // R3: one push per call
  a_r3_push_once: assert property (@(posedge clk) disable iff (!rstN)
    pushReq |=> !pushReq);
  // R4: interrupt enable is restored together with the commit
  a_r4_ie_with_load: assert property (@(posedge clk) disable iff (!rstN)
    intEnableSet |-> (pcLoad && !pushReq));

endmodule

// File: rtl/pcbu_dpath.sv
module pcbu_dpath
  import pcbu_pkg::*;
#(
  parameter int PC_W  = 13,
  parameter int OFF_W = 12,
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          dpCtrl,
  input  logic             busy,
  input  logic [PC_W-1:0]  curPc,
  input  logic [OFF_W-1:0] offset,
  input  logic [PTR_W-1:0] ptrVal,
  input  logic [PC_W-1:0]  retAddr,
  output logic [PC_W-1:0]  nextPc,
  output logic [PC_W-1:0]  pushAddr
);

  logic [PC_W-1:0] offExt;
  logic [PC_W-1:0] seqPc;
  logic [PC_W-1:0] relPc;
  logic [PC_W-1:0] ptrPc;
  logic [PC_W-1:0] candPc;

  assign offExt = PC_W'($signed(offset));
  assign seqPc  = curPc + PC_W'(1);
  assign relPc  = seqPc + offExt;

  generate
    if (PTR_W >= PC_W) begin : g_ptrTrunc
      assign ptrPc = ptrVal[PC_W-1:0];
    end else begin : g_ptrZext
      assign ptrPc = {{(PC_W-PTR_W){1'b0}}, ptrVal};
    end
  endgenerate

  always_comb begin
    case (dpCtrl.sel)
      SEL_REL:   candPc = relPc;
      SEL_PTR:   candPc = ptrPc;
      SEL_RET:   candPc = retAddr;
      SEL_SKIP2: candPc = curPc + PC_W'(2);
      SEL_SKIP3: candPc = curPc + PC_W'(3);
      default:   candPc = seqPc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextPc   <= '0;
      pushAddr <= '0;
    end else if (dpCtrl.latch) begin
      nextPc   <= candPc;
      pushAddr <= seqPc;
    end
  end

  // R9: the target is frozen while an operation runs
  a_r9_hold_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(nextPc));
  // R9: a latch is never requested while busy
  a_r9_no_latch_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !dpCtrl.latch);

endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit
  import pcbu_pkg::*;
#(
  parameter int PC_W   = 13,
  parameter int OFF_W  = 12,
  parameter int PTR_W  = 16,
  parameter int SREG_W = 8,
  parameter int SEL_W  = $clog2(SREG_W),
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opKind,
  input  logic [PC_W-1:0]   curPc,
  input  logic [OFF_W-1:0]  offset,
  input  logic [PTR_W-1:0]  ptrVal,
  input  logic [PC_W-1:0]   retAddr,
  input  logic [SREG_W-1:0] statusReg,
  input  logic [SEL_W-1:0]  bitSel,
  input  logic              skipCond,
  input  logic              nextTwoWord,
  output logic              busy,
  output logic [CNT_W-1:0]  cycLen,
  output logic              pcLoad,
  output logic [PC_W-1:0]   nextPc,
  output logic              pushReq,
  output logic [PC_W-1:0]   pushAddr,
  output logic              intEnableSet
);

  dpCtrl_t dpCtrl;

  pcbu_ctrl #(
    .SREG_W(SREG_W), .SEL_W(SEL_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
    .statusReg(statusReg), .bitSel(bitSel), .skipCond(skipCond),
    .nextTwoWord(nextTwoWord), .dpCtrl(dpCtrl), .busy(busy),
    .cycLen(cycLen), .pcLoad(pcLoad), .pushReq(pushReq),
    .intEnableSet(intEnableSet)
  );

  pcbu_dpath #(
    .PC_W(PC_W), .OFF_W(OFF_W), .PTR_W(PTR_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl), .busy(busy),
    .curPc(curPc), .offset(offset), .ptrVal(ptrVal), .retAddr(retAddr),
    .nextPc(nextPc), .pushAddr(pushAddr)
  );

endmodule

// File: tb/sim_pc_branch_unit.sv
module sim_pc_branch_unit;

  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 13;
  localparam int OFF_W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [3:0] opKind = '0;
  logic [PC_W-1:0] curPc = '0;
  logic [OFF_W-1:0] offset = '0;
  logic [15:0] ptrVal = '0;
  logic [PC_W-1:0] retAddr = '0;
  logic [7:0] statusReg = '0;
  logic [2:0] bitSel = '0;
  logic skipCond = 1'b0;
  logic nextTwoWord = 1'b0;
  logic busy;
  logic [2:0] cycLen;
  logic pcLoad;
  logic [PC_W-1:0] nextPc;
  logic pushReq;
  logic [PC_W-1:0] pushAddr;
  logic intEnableSet;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_branch_unit u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
    .curPc(curPc), .offset(offset), .ptrVal(ptrVal), .retAddr(retAddr),
    .statusReg(statusReg), .bitSel(bitSel), .skipCond(skipCond),
    .nextTwoWord(nextTwoWord), .busy(busy), .cycLen(cycLen),
    .pcLoad(pcLoad), .nextPc(nextPc), .pushReq(pushReq),
    .pushAddr(pushAddr), .intEnableSet(intEnableSet)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic string reqOf(input logic [3:0] k);
    case (k)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4, 4'd5: return "R4";
      4'd6, 4'd7: return "R5";
      4'd8, 4'd9: return "R6";
      4'd10: return "R7";
      default: return "R11";
    endcase
  endfunction

  // reference model built from the requirements
  function automatic void model(
    input logic [3:0] k, input logic [PC_W-1:0] pc, input logic [OFF_W-1:0] off,
    input logic [15:0] ptr, input logic [PC_W-1:0] ret, input logic [7:0] sr,
    input logic [2:0] bs, input logic sc, input logic tw,
    output logic [PC_W-1:0] epc, output int ecyc, output bit ecall, output bit ereti);
    logic [PC_W-1:0] rel;
    bit taken;
    rel = pc + {{(PC_W-OFF_W){off[OFF_W-1]}}, off} + 1'b1;
    epc = pc + 1'b1; ecyc = 1; ecall = 0; ereti = 0; taken = 0;
    case (k)
      4'd0: begin epc = rel; ecyc = 2; end
      4'd1: begin epc = ptr[PC_W-1:0]; ecyc = 2; end
      4'd2: begin epc = rel; ecyc = 3; ecall = 1; end
      4'd3: begin epc = ptr[PC_W-1:0]; ecyc = 3; ecall = 1; end
      4'd4: begin epc = ret; ecyc = 4; end
      4'd5: begin epc = ret; ecyc = 4; ereti = 1; end
      4'd6: taken = sr[bs];
      4'd7: taken = !sr[bs];
      4'd8: taken = !(sr[2] ^ sr[3]);
      4'd9: taken = sr[2] ^ sr[3];
      4'd10: if (sc) begin epc = pc + (tw ? 3 : 2); ecyc = tw ? 3 : 2; end
      default: ;
    endcase
    if (taken) begin epc = rel; ecyc = 2; end
  endfunction

  task automatic runOp(
    input logic [3:0] k, input logic [PC_W-1:0] pc, input logic [OFF_W-1:0] off,
    input logic [15:0] ptr, input logic [PC_W-1:0] ret, input logic [7:0] sr,
    input logic [2:0] bs, input logic sc, input logic tw, input bit intrude);
    logic [PC_W-1:0] epc;
    int ecyc;
    bit ecall, ereti;
    int busyCnt = 0, loadCnt = 0, loadIdx = 0, pushCnt = 0, pushIdx = 0;
    int ieCnt = 0, ieIdx = 0, lenSeen = 0;
    logic [PC_W-1:0] pcSeen = '0, pushSeen = '0;
    string rq;
    rq = reqOf(k);
    model(k, pc, off, ptr, ret, sr, bs, sc, tw, epc, ecyc, ecall, ereti);
    @(negedge clk);
    opValid = 1'b1; opKind = k; curPc = pc; offset = off; ptrVal = ptr;
    retAddr = ret; statusReg = sr; bitSel = bs; skipCond = sc; nextTwoWord = tw;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (i == 1) lenSeen = int'(cycLen);
      if (busy) busyCnt++;
      if (pcLoad) begin loadCnt++; loadIdx = i; pcSeen = nextPc; end
      if (pushReq) begin pushCnt++; pushIdx = i; pushSeen = pushAddr; end
      if (intEnableSet) begin ieCnt++; ieIdx = i; end
      opValid = intrude && (i < ecyc);
      if (intrude) begin
        opKind = 4'($urandom); curPc = PC_W'($urandom); offset = OFF_W'($urandom);
        ptrVal = 16'($urandom); retAddr = PC_W'($urandom); statusReg = 8'($urandom);
        skipCond = 1'($urandom); nextTwoWord = 1'($urandom);
      end
    end
    chk(pcSeen == epc, rq, int'(pcSeen), int'(epc));
    chk(busyCnt == ecyc, "R8 busy length", busyCnt, ecyc);
    chk(loadCnt == 1 && loadIdx == ecyc, "R8 load cycle", loadIdx, ecyc);
    chk(lenSeen == ecyc, "R8 cycLen", lenSeen, ecyc);
    if (ecall) begin
      chk(pushCnt == 1 && pushIdx == 1, "R3 push cycle", pushIdx, 1);
      chk(pushSeen == pc + 1'b1, "R3 push address", int'(pushSeen), int'(pc + 1'b1));
    end else begin
      chk(pushCnt == 0, {rq, " no push"}, pushCnt, 0);
    end
    if (ereti) chk(ieCnt == 1 && ieIdx == ecyc, "R4 reti strobe", ieIdx, ecyc);
    else       chk(ieCnt == 0, {rq, " no ie strobe"}, ieCnt, 0);
    if (intrude) chk(!busy, "R9 no accept while busy", int'(busy), 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!busy && !pcLoad && !pushReq && !intEnableSet, "R10 strobes", int'({busy, pcLoad, pushReq, intEnableSet}), 0);
    chk(nextPc == 0 && pushAddr == 0 && cycLen == 0, "R10 registers", int'(nextPc), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R1: wrap at top, negative offset, positive offset
    runOp(4'd0, 13'h1FFF, 12'h000, 16'h0, 13'h0, 8'h00, 3'd0, 0, 0, 0);
    runOp(4'd0, 13'h0005, 12'hFFA, 16'h0, 13'h0, 8'h00, 3'd0, 0, 0, 0);
    runOp(4'd0, 13'h0100, 12'h7FF, 16'h0, 13'h0, 8'h00, 3'd0, 0, 0, 0);
    // R2: pointer truncation
    runOp(4'd1, 13'h0010, 12'h000, 16'hABCD, 13'h0, 8'h00, 3'd0, 0, 0, 0);
    // R3: calls
    runOp(4'd2, 13'h0200, 12'hF00, 16'h0, 13'h0, 8'h00, 3'd0, 0, 0, 0);
    runOp(4'd3, 13'h1FFF, 12'h000, 16'h1234, 13'h0, 8'h00, 3'd0, 0, 0, 0);
    // R4: returns
    runOp(4'd4, 13'h0300, 12'h000, 16'h0, 13'h0ABC, 8'h00, 3'd0, 0, 0, 0);
    runOp(4'd5, 13'h0300, 12'h000, 16'h0, 13'h1555, 8'h00, 3'd0, 0, 0, 0);
    // R5: bit branches taken and not taken
    runOp(4'd6, 13'h0040, 12'h010, 16'h0, 13'h0, 8'h80, 3'd7, 0, 0, 0);
    runOp(4'd6, 13'h0040, 12'h010, 16'h0, 13'h0, 8'h7F, 3'd7, 0, 0, 0);
    runOp(4'd7, 13'h0040, 12'hFF0, 16'h0, 13'h0, 8'hFE, 3'd0, 0, 0, 0);
    // R6: signed conditions
    runOp(4'd8, 13'h0050, 12'h020, 16'h0, 13'h0, 8'h0C, 3'd0, 0, 0, 0);
    runOp(4'd8, 13'h0050, 12'h020, 16'h0, 13'h0, 8'h04, 3'd0, 0, 0, 0);
    runOp(4'd9, 13'h0050, 12'h020, 16'h0, 13'h0, 8'h04, 3'd0, 0, 0, 0);
    runOp(4'd9, 13'h0050, 12'h020, 16'h0, 13'h0, 8'h00, 3'd0, 0, 0, 0);
    // R7: skip variants
    runOp(4'd10, 13'h0060, 12'h000, 16'h0, 13'h0, 8'h00, 3'd0, 0, 1, 0);
    runOp(4'd10, 13'h0060, 12'h000, 16'h0, 13'h0, 8'h00, 3'd0, 1, 0, 0);
    runOp(4'd10, 13'h1FFE, 12'h000, 16'h0, 13'h0, 8'h00, 3'd0, 1, 1, 0);
    // R11: unused code
    runOp(4'd13, 13'h0070, 12'h123, 16'h0, 13'h0, 8'hFF, 3'd0, 1, 1, 0);
    // R9: intrusion during a return and a call
    runOp(4'd4, 13'h0400, 12'h000, 16'h0, 13'h0777, 8'h00, 3'd0, 0, 0, 1);
    runOp(4'd2, 13'h0400, 12'h005, 16'h0, 13'h0, 8'h00, 3'd0, 0, 0, 1);
    // random mix
    for (int n = 0; n < 300; n++) begin
      runOp(4'($urandom), PC_W'($urandom), OFF_W'($urandom), 16'($urandom),
            PC_W'($urandom), 8'($urandom), 3'($urandom), 1'($urandom),
            1'($urandom), ($urandom % 4) == 0);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule